// File: doc/BRIEF.md
# Bidirectional GPIO Port with Read-Modify-Write Readback

This block controls a bank of general-purpose pins, eight by default. A small register bus reaches two registers. The output value register holds the level each pin drives when it acts as a general output. The direction register turns each pin's driver on or off. A pin can also be taken over by a peripheral function output or by an LCD segment signal. Every pin sends its level back to a peripheral input through a two-flop synchronizer.

Bus reads of the output value register come in two kinds. A plain read returns the synchronized level seen on the pins. A read flagged as part of a read-modify-write returns the stored register value instead. This lets software change single bits without copying pin levels into the register. A hold input stands for the low-power state with the pin-state control set. While it is high, every driver is turned off and the input path is blocked.

Top module: `gpio_rmw_port`

## Requirements
- R1: After reset both registers are 0. With no LCD or peripheral enable, `padOe` is 0, and the bus reads of both registers return 0.
- R2: Register address 1 is the direction register and address 0 is the output value register. Direction bit n set to 1 turns on the driver of pin n (`padOe[n]`), and `padOut[n]` then carries output value bit n. A direction bit of 0 leaves the pin as an input.
- R3: A read strobe with `busRmw` low at address 0 loads `busRdata` at the next clock edge with the pin levels. Each level is `padIn` delayed by two flops.
- R4: A read strobe with `busRmw` high at address 0 loads `busRdata` with the stored output value register, whatever the pins show.
- R5: A write to address 0 updates the output value register even while the pin is an input. A pin later switched to output drives the written value.
- R6: `periOe[n]` set (and `lcdOe[n]` clear) makes `padOut[n]` follow `periOut[n]` and forces `padOe[n]` to 1, whatever the direction bit says.
- R7: `lcdOe[n]` has top priority. It makes `padOut[n]` follow `lcdSeg[n]` and forces `padOe[n]` to 1, over the peripheral enable and the direction bit.
- R8: While `lowPwrHold` is 1, `padOe`, `padOut` and `periIn` are all 0, and a plain read at address 0 returns 0. A read-modify-write read still returns the stored value.
- R9: A read at address 1 returns the direction register, whatever the value of `busRmw`.
- R10: When `lowPwrHold` is 0, `periIn` equals the synchronized pin level. A change on `padIn` shows up after exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Register select: 0 output value, 1 direction |
| busRd | input | 1 | Read strobe |
| busRmw | input | 1 | Marks the read as part of a read-modify-write |
| busWr | input | 1 | Write strobe |
| busWdata | input | W | Write data |
| busRdata | output | W | Registered read data |
| lowPwrHold | input | 1 | Low-power pin hold: drivers off, input path blocked |
| periOe | input | W | Peripheral output enable per pin |
| periOut | input | W | Peripheral output level per pin |
| lcdOe | input | W | LCD segment enable per pin |
| lcdSeg | input | W | LCD segment level per pin |
| padIn | input | W | Level seen at each pad |
| padOut | output | W | Level driven toward each pad |
| padOe | output | W | Driver enable per pad |
| periIn | output | W | Synchronized pin level for peripherals |

## Verification
A wrong output value register or direction register shows at `padOut` and `padOe` in the cycle after the write. The stored value also comes back on the bus one cycle after a read-modify-write read, even when the pins say otherwise. A synchronizer with the wrong depth moves the edge on `periIn` and on the plain readback by a full cycle, so the bench samples one cycle early as well as on time. A mistake in the source priority or the hold gating shows at once on the pad outputs, for whichever enables are active.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;
  // Strobes from bus decode to the datapath, valid for one cycle
  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic rdData;
    logic rdDir;
    logic rdRmw;
  } regStrobe_t;
endpackage

// File: rtl/gpio_rmw_ctrl.sv
module gpio_rmw_ctrl
  import gpio_rmw_pkg::*;
#(
  parameter int ADDR_W    = 1,
  parameter int DATA_ADDR = 0,
  parameter int DIR_ADDR  = 1
) (
  input  logic              busRd,
  input  logic              busRmw,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] DataSel = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] DirSel  = ADDR_W'(DIR_ADDR);

  logic hitData, hitDir;

  always_comb begin
    hitData     = (busAddr == DataSel);
    hitDir      = (busAddr == DirSel);
    strb.wrData = busWr & hitData;
    strb.wrDir  = busWr & hitDir;
    strb.rdData = busRd & hitData;
    strb.rdDir  = busRd & hitDir;
    strb.rdRmw  = busRd & busRmw;
  end
endmodule

// File: rtl/gpio_rmw_dpath.sv
module gpio_rmw_dpath
  import gpio_rmw_pkg::*;
#(
  parameter int W         = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  regStrobe_t   strb,
  input  logic [W-1:0] busWdata,
  output logic [W-1:0] busRdata,
  input  logic         lowPwrHold,
  input  logic [W-1:0] periOe,
  input  logic [W-1:0] periOut,
  input  logic [W-1:0] lcdOe,
  input  logic [W-1:0] lcdSeg,
  input  logic [W-1:0] padIn,
  output logic [W-1:0] padOut,
  output logic [W-1:0] padOe,
  output logic [W-1:0] periIn
);
  logic [W-1:0] dataLatch, dirReg, pinLvl, rdReg;
  logic [W-1:0] syncStage [SYNC_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataLatch <= '0;
      dirReg    <= '0;
    end else begin
      if (strb.wrData) dataLatch <= busWdata;
      if (strb.wrDir)  dirReg    <= busWdata;
    end
  end

  // Synchronizer chain on the pad inputs
  genvar s;
  generate
    for (s = 0; s < SYNC_DEPTH; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncStage[s] <= '0;
        else if (s == 0) syncStage[s] <= padIn;
        else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinLvl = lowPwrHold ? '0 : syncStage[SYNC_DEPTH-1];
  assign periIn = pinLvl;

  // Per-pin source selection: LCD, then peripheral, then latch
  genvar n;
  generate
    for (n = 0; n < W; n++) begin : g_pin
      always_comb begin
        if (lowPwrHold) begin
          padOut[n] = 1'b0;
          padOe[n]  = 1'b0;
        end else if (lcdOe[n]) begin
          padOut[n] = lcdSeg[n];
          padOe[n]  = 1'b1;
        end else if (periOe[n]) begin
          padOut[n] = periOut[n];
          padOe[n]  = 1'b1;
        end else begin
          padOut[n] = dataLatch[n];
          padOe[n]  = dirReg[n];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdReg <= '0;
    else if (strb.rdData) rdReg <= strb.rdRmw ? dataLatch : pinLvl;
    else if (strb.rdDir) rdReg <= dirReg;
  end

  assign busRdata = rdReg;
endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
  import gpio_rmw_pkg::*;
#(
  parameter int W         = 8,
  parameter int ADDR_W    = 1,
  parameter int DATA_ADDR = 0,
  parameter int DIR_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busRmw,
  input  logic              busWr,
  input  logic [W-1:0]      busWdata,
  output logic [W-1:0]      busRdata,
  input  logic              lowPwrHold,
  input  logic [W-1:0]      periOe,
  input  logic [W-1:0]      periOut,
  input  logic [W-1:0]      lcdOe,
  input  logic [W-1:0]      lcdSeg,
  input  logic [W-1:0]      padIn,
  output logic [W-1:0]      padOut,
  output logic [W-1:0]      padOe,
  output logic [W-1:0]      periIn
);
  regStrobe_t strb;

  gpio_rmw_ctrl #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)) u_ctrl (
    .busRd(busRd), .busRmw(busRmw), .busWr(busWr), .busAddr(busAddr), .strb(strb)
  );

  gpio_rmw_dpath #(.W(W), .SYNC_DEPTH(2)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .busRdata(busRdata),
    .lowPwrHold(lowPwrHold), .periOe(periOe), .periOut(periOut), .lcdOe(lcdOe),
    .lcdSeg(lcdSeg), .padIn(padIn), .padOut(padOut), .padOe(padOe), .periIn(periIn)
  );
endmodule

// File: rtl/gpio_rmw_port_chk.sv
module gpio_rmw_port_chk #(
  parameter int W         = 8,
  parameter int ADDR_W    = 1,
  parameter int DATA_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busRmw,
  input logic              busWr,
  input logic [W-1:0]      busWdata,
  input logic [W-1:0]      busRdata,
  input logic              lowPwrHold,
  input logic [W-1:0]      periOe,
  input logic [W-1:0]      periOut,
  input logic [W-1:0]      lcdOe,
  input logic [W-1:0]      lcdSeg,
  input logic [W-1:0]      padOut,
  input logic [W-1:0]      padOe,
  input logic [W-1:0]      periIn
);
  localparam logic [ADDR_W-1:0] DataSel = ADDR_W'(DATA_ADDR);

  // R8
  hold_drivers_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowPwrHold |-> (padOe == '0 && padOut == '0 && periIn == '0));

  // R6
  takeover_forces_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lowPwrHold |-> (((lcdOe | periOe) & ~padOe) == '0));

  // R7
  lcd_drives_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lowPwrHold |-> ((lcdOe & (padOut ^ lcdSeg)) == '0));

  // R6
  peri_drives_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lowPwrHold |-> ((periOe & ~lcdOe & (padOut ^ periOut)) == '0));

  // R4
  rmw_returns_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busWr && busAddr == DataSel, 2) &&
     $past(busRd && busRmw && busAddr == DataSel && !busWr, 1))
    |-> busRdata == $past(busWdata, 2));
endmodule

bind gpio_rmw_port gpio_rmw_port_chk #(.W(W), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busRmw(busRmw),
  .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .lowPwrHold(lowPwrHold),
  .periOe(periOe), .periOut(periOut), .lcdOe(lcdOe), .lcdSeg(lcdSeg),
  .padOut(padOut), .padOe(padOe), .periIn(periIn)
);

// File: tb/gpio_rmw_port_tb.sv
module gpio_rmw_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [0:0] busAddr = '0;
  logic busRd = 1'b0, busRmw = 1'b0, busWr = 1'b0;
  logic [W-1:0] busWdata = '0, busRdata;
  logic lowPwrHold = 1'b0;
  logic [W-1:0] periOe = '0, periOut = '0, lcdOe = '0, lcdSeg = '0, padIn = '0;
  logic [W-1:0] padOut, padOe, periIn;

  int nRun = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_rmw_port u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busRmw(busRmw),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .lowPwrHold(lowPwrHold),
    .periOe(periOe), .periOut(periOut), .lcdOe(lcdOe), .lcdSeg(lcdSeg),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .periIn(periIn)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic a, input logic [W-1:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic a, input logic rmw, output logic [W-1:0] d);
    @(negedge clk);
    busAddr = a; busRmw = rmw; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0; busRmw = 1'b0;
    d = busRdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    logic [W-1:0] d;
    chk("R1 padOe", padOe, '0);
    busRead(1'b1, 1'b0, d); chk("R1 dir read", d, '0);
    busRead(1'b0, 1'b1, d); chk("R1 data rmw read", d, '0);
  endtask

  task automatic testDirection();
    busWrite(1'b1, 8'h0F);
    busWrite(1'b0, 8'hA5);
    chk("R2 padOe", padOe, 8'h0F);
    chk("R2 padOut low nibble", padOut & 8'h0F, 8'h05);
  endtask

  task automatic testReads();
    logic [W-1:0] d;
    @(negedge clk); padIn = 8'h3C;
    settle();
    busRead(1'b0, 1'b0, d); chk("R3 plain read pins", d, 8'h3C);
    busRead(1'b0, 1'b1, d); chk("R4 rmw read latch", d, 8'hA5);
    busRead(1'b1, 1'b0, d); chk("R9 dir plain read", d, 8'h0F);
    busRead(1'b1, 1'b1, d); chk("R9 dir rmw read", d, 8'h0F);
  endtask

  task automatic testWriteWhileInput();
    busWrite(1'b1, 8'h00);
    busWrite(1'b0, 8'h5A);
    chk("R5 inputs stay off", padOe, 8'h00);
    busWrite(1'b1, 8'hFF);
    chk("R5 padOe all", padOe, 8'hFF);
    chk("R5 padOut written", padOut, 8'h5A);
    busWrite(1'b1, 8'h00);
  endtask

  task automatic testPeripheral();
    @(negedge clk); periOe = 8'hF0; periOut = 8'h30;
    @(negedge clk);
    chk("R6 padOe", padOe, 8'hF0);
    chk("R6 padOut high nibble", padOut & 8'hF0, 8'h30);
  endtask

  task automatic testLcd();
    @(negedge clk); periOe = 8'hFF; periOut = 8'h00; lcdOe = 8'h81; lcdSeg = 8'h01;
    @(negedge clk);
    chk("R7 padOe", padOe, 8'hFF);
    chk("R7 padOut", padOut, 8'h01);
    @(negedge clk); periOe = '0; lcdOe = '0; lcdSeg = '0;
  endtask

  task automatic testHold();
    logic [W-1:0] d;
    busWrite(1'b1, 8'hFF);
    @(negedge clk); lowPwrHold = 1'b1; lcdOe = 8'h0F; lcdSeg = 8'h0F;
    @(negedge clk);
    chk("R8 padOe", padOe, '0);
    chk("R8 padOut", padOut, '0);
    chk("R8 periIn", periIn, '0);
    busRead(1'b0, 1'b0, d); chk("R8 plain read blocked", d, '0);
    busRead(1'b0, 1'b1, d); chk("R8 rmw read kept", d, 8'h5A);
    @(negedge clk); lowPwrHold = 1'b0; lcdOe = '0; lcdSeg = '0;
    busWrite(1'b1, 8'h00);
  endtask

  task automatic testSyncDepth();
    @(negedge clk); padIn = 8'h11;
    settle();
    chk("R10 periIn settled", periIn, 8'h11);
    @(negedge clk); padIn = 8'hE7;
    @(negedge clk);
    chk("R10 one edge still old", periIn, 8'h11);
    @(negedge clk);
    chk("R10 two edges new", periIn, 8'hE7);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirection();
    testReads();
    testWriteWhileInput();
    testPeripheral();
    @(negedge clk); periOe = '0; periOut = '0;
    testLcd();
    testHold();
    testSyncDepth();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule